// File: doc/BRIEF.md
# Shared-Port Local/Outbound Route Switch

This block sits behind a shared slave port that carries both register traffic meant for the controller itself and memory traffic meant to leave the chip through the outbound address translator. Each request picks its own route from one sideband bit. That bit sits at position 21 of the per-channel misc word by default. When the bit is 1, the request is served by the local register bus inside this block. When it is 0, the request is forwarded unchanged on the outbound master port. The read and write channels each use their own sideband word, and each channel is routed on its own.

The local register space holds two separate banks. A chip-select-2 address bit, at position 12 by default, chooses between them. With the bit clear, an access reaches the normal bank. With it set, the access reaches the shadow bank. The shadow bank has its own storage and its own write enables, and no outbound request can reach it. Responses go back to the initiator in request order on each channel, even when local and outbound requests are interleaved.

Every request and response channel is valid/ready. A request transfers on a cycle where valid and ready are both high. Once a response valid is raised, the initiator side holds it, with its payload stable, until ready is seen. A local request is accepted whenever the order queue and the local response queue have room. An outbound request is accepted only while the outbound port is ready, so back-pressure from the translator passes straight through to the initiator.

Top module: `dbi_route_switch`

## Requirements
- R1: A read whose misc bit ROUTE_BIT (21) is 1 is served locally, with response OKAY (2'b00). It never appears on the outbound read port.
- R2: A write whose misc bit ROUTE_BIT (21) is 1 is served locally, with response OKAY (2'b00). It never appears on the outbound write port.
- R3: A request whose route bit is 0 is forwarded with its address (and its write data) unchanged. The outbound response payload is returned unchanged to the initiator.
- R4: The read and write channels route independently. A local request on one channel and an outbound request on the other may be accepted in the same cycle.
- R5: On the local path, address bit CS2_BIT (12) set selects the shadow bank and clear selects the normal bank. The word index is address bits [CS2_BIT-1:2]. The normal bank has NREG words (8) and the shadow bank has SREG words (4). Both banks reset to zero.
- R6: An outbound request never changes the shadow bank, whatever its CS2 bit.
- R7: On each channel, responses return in the order the requests were accepted, across both paths. A finished local response waits behind an earlier outbound one.
- R8: A local access to an index outside its bank returns SLVERR (2'b10). A read of such an index returns all-ones data, and a write to it changes nothing.
- R9: A request transfers only when valid and ready are both high. Outbound back-pressure holds the request ready low. A response that is not taken stays valid with stable payload.
- R10: After reset, no response is valid, and reads of both banks return zero.
- R11: A local read and a local write to the same word, accepted in the same cycle, return the old value for the read. The new value is visible from the next read on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_wr_valid | input | 1 | Write request valid |
| s_wr_ready | output | 1 | Write request ready |
| s_wr_addr | input | ADDR_W | Write address |
| s_wr_data | input | DATA_W | Write data |
| s_wr_misc | input | MISC_W | Write sideband; bit ROUTE_BIT selects local |
| s_wb_valid | output | 1 | Write response valid |
| s_wb_ready | input | 1 | Write response ready |
| s_wb_resp | output | 2 | Write response code |
| s_rd_valid | input | 1 | Read request valid |
| s_rd_ready | output | 1 | Read request ready |
| s_rd_addr | input | ADDR_W | Read address |
| s_rd_misc | input | MISC_W | Read sideband; bit ROUTE_BIT selects local |
| s_rr_valid | output | 1 | Read response valid |
| s_rr_ready | input | 1 | Read response ready |
| s_rr_data | output | DATA_W | Read response data |
| s_rr_resp | output | 2 | Read response code |
| m_wr_valid | output | 1 | Outbound write valid |
| m_wr_ready | input | 1 | Outbound write ready |
| m_wr_addr | output | ADDR_W | Outbound write address |
| m_wr_data | output | DATA_W | Outbound write data |
| m_wb_valid | input | 1 | Outbound write response valid |
| m_wb_ready | output | 1 | Outbound write response ready |
| m_wb_resp | input | 2 | Outbound write response code |
| m_rd_valid | output | 1 | Outbound read valid |
| m_rd_ready | input | 1 | Outbound read ready |
| m_rd_addr | output | ADDR_W | Outbound read address |
| m_rr_valid | input | 1 | Outbound read response valid |
| m_rr_ready | output | 1 | Outbound read response ready |
| m_rr_data | input | DATA_W | Outbound read response data |
| m_rr_resp | input | 2 | Outbound read response code |

## Verification
Two functions can land in the same cycle. The first pair is a local read and a local write. The bench starts both together on the same word, so the single register array sees a read and an update at one edge. The read must return the value from before the write, and a following read must show the new one. The second pair is a local request on one channel and an outbound request on the other. The bench launches both together and checks that each lands on its own path. It also holds an outbound read response back while a later local response is already queued. That local response must stay hidden until the outbound one has been delivered.

// File: rtl/dbi_route_pkg.sv
package dbi_route_pkg;
  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_EXOKAY = 2'b01;
  localparam logic [1:0] RSP_SLVERR = 2'b10;
endpackage

// File: rtl/rs_fifo.sv
module rs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: order storage never overflows or underflows
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop));
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/rs_chan.sv
module rs_chan #(
  parameter int REQ_W = 32,
  parameter int RSP_W = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_req_valid,
  input  logic             s_req_route,
  input  logic [REQ_W-1:0] s_req_pay,
  output logic             s_req_ready,
  output logic             m_req_valid,
  input  logic             m_req_ready,
  output logic [REQ_W-1:0] m_req_pay,
  output logic             loc_fire,
  input  logic [RSP_W-1:0] loc_rsp,
  input  logic             m_rsp_valid,
  output logic             m_rsp_ready,
  input  logic [RSP_W-1:0] m_rsp_pay,
  output logic             s_rsp_valid,
  input  logic             s_rsp_ready,
  output logic [RSP_W-1:0] s_rsp_pay
);
  logic ord_full, ord_empty, ord_head;
  logic loc_full, loc_empty;
  logic [RSP_W-1:0] loc_head;
  logic acc, deliver;

  assign s_req_ready = !ord_full && (s_req_route ? !loc_full : m_req_ready);
  assign m_req_valid = s_req_valid && !s_req_route && !ord_full;
  assign m_req_pay   = s_req_pay;
  assign acc         = s_req_valid && s_req_ready;
  assign loc_fire    = acc && s_req_route;

  assign s_rsp_valid = !ord_empty && (ord_head ? !loc_empty : m_rsp_valid);
  assign s_rsp_pay   = ord_head ? loc_head : m_rsp_pay;
  assign m_rsp_ready = !ord_empty && !ord_head && s_rsp_ready;
  assign deliver     = s_rsp_valid && s_rsp_ready;

  rs_fifo #(.W(1), .DEPTH(DEPTH)) u_order (
    .clk(clk), .rst_n(rst_n), .push(acc), .din(s_req_route), .pop(deliver),
    .dout(ord_head), .full(ord_full), .empty(ord_empty)
  );

  rs_fifo #(.W(RSP_W), .DEPTH(DEPTH)) u_lrsp (
    .clk(clk), .rst_n(rst_n), .push(loc_fire), .din(loc_rsp), .pop(deliver && ord_head),
    .dout(loc_head), .full(loc_full), .empty(loc_empty)
  );

  // R9: a response not taken is held with stable payload
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rsp_valid && !s_rsp_ready) |=> (s_rsp_valid && $stable(s_rsp_pay)));
  // R7: an outbound response is only taken when it is passed to the initiator
  a_r7_ob_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rsp_valid && m_rsp_ready) |-> (s_rsp_valid && s_rsp_pay == m_rsp_pay));
  // R9: outbound back-pressure blocks an outbound request
  a_r9_ob_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req_valid && !s_req_route && !m_req_ready) |-> !s_req_ready);
endmodule

// File: rtl/rs_regbank.sv
module rs_regbank
  import dbi_route_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 10,
  parameter int NREG  = 8,
  parameter int SREG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [1:0]       wr_resp,
  input  logic             rd_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [1:0]       rd_resp
);
  logic [NREG-1:0][DW-1:0] norm_q;
  logic [SREG-1:0][DW-1:0] shad_q;
  logic wr_hit;

  assign wr_hit  = wr_sel ? (int'(wr_idx) < SREG) : (int'(wr_idx) < NREG);
  assign wr_resp = wr_hit ? RSP_OKAY : RSP_SLVERR;

  for (genvar g = 0; g < NREG; g++) begin : g_norm
    always_ff @(posedge clk) begin
      if (!rst_n) norm_q[g] <= '0;
      else if (wr_en && !wr_sel && wr_idx == IDX_W'(g)) norm_q[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < SREG; g++) begin : g_shad
    always_ff @(posedge clk) begin
      if (!rst_n) shad_q[g] <= '0;
      else if (wr_en && wr_sel && wr_idx == IDX_W'(g)) shad_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '1;
    rd_resp = RSP_SLVERR;
    if (rd_sel) begin
      for (int i = 0; i < SREG; i++) begin
        if (rd_idx == IDX_W'(i)) begin
          rd_data = shad_q[i];
          rd_resp = RSP_OKAY;
        end
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (rd_idx == IDX_W'(i)) begin
          rd_data = norm_q[i];
          rd_resp = RSP_OKAY;
        end
      end
    end
  end

  // R6: the shadow bank changes only on a local write with CS2 set
  a_r6_shadow_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(shad_q));
  // R8: an unmapped write leaves both banks untouched
  a_r8_unmapped_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_resp == RSP_SLVERR) |=> ($stable(shad_q) && $stable(norm_q)));
endmodule

// File: rtl/dbi_route_switch.sv
module dbi_route_switch
  import dbi_route_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MISC_W    = 24,
  parameter int ROUTE_BIT = 21,
  parameter int CS2_BIT   = 12,
  parameter int NREG      = 8,
  parameter int SREG      = 4,
  parameter int DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_wr_valid,
  output logic              s_wr_ready,
  input  logic [ADDR_W-1:0] s_wr_addr,
  input  logic [DATA_W-1:0] s_wr_data,
  input  logic [MISC_W-1:0] s_wr_misc,
  output logic              s_wb_valid,
  input  logic              s_wb_ready,
  output logic [1:0]        s_wb_resp,
  input  logic              s_rd_valid,
  output logic              s_rd_ready,
  input  logic [ADDR_W-1:0] s_rd_addr,
  input  logic [MISC_W-1:0] s_rd_misc,
  output logic              s_rr_valid,
  input  logic              s_rr_ready,
  output logic [DATA_W-1:0] s_rr_data,
  output logic [1:0]        s_rr_resp,
  output logic              m_wr_valid,
  input  logic              m_wr_ready,
  output logic [ADDR_W-1:0] m_wr_addr,
  output logic [DATA_W-1:0] m_wr_data,
  input  logic              m_wb_valid,
  output logic              m_wb_ready,
  input  logic [1:0]        m_wb_resp,
  output logic              m_rd_valid,
  input  logic              m_rd_ready,
  output logic [ADDR_W-1:0] m_rd_addr,
  input  logic              m_rr_valid,
  output logic              m_rr_ready,
  input  logic [DATA_W-1:0] m_rr_data,
  input  logic [1:0]        m_rr_resp
);
  localparam int IDX_W  = CS2_BIT - 2;
  localparam int WREQ_W = ADDR_W + DATA_W;
  localparam int RRSP_W = DATA_W + 2;

  logic wr_route, rd_route;
  logic wr_loc_fire, rd_loc_fire;
  logic [1:0] loc_wr_resp, loc_rd_resp;
  logic [DATA_W-1:0] loc_rd_data;
  logic [WREQ_W-1:0] m_wr_pay;
  logic [RRSP_W-1:0] s_rr_pay;
  logic unused_bits;

  assign wr_route = s_wr_misc[ROUTE_BIT];
  assign rd_route = s_rd_misc[ROUTE_BIT];
  assign unused_bits = ^{s_wr_misc, s_rd_misc, s_wr_addr[ADDR_W-1:CS2_BIT+1],
                         s_wr_addr[1:0], s_rd_addr[ADDR_W-1:CS2_BIT+1], s_rd_addr[1:0]};

  rs_chan #(.REQ_W(WREQ_W), .RSP_W(2), .DEPTH(DEPTH)) u_wchan (
    .clk(clk), .rst_n(rst_n),
    .s_req_valid(s_wr_valid), .s_req_route(wr_route), .s_req_pay({s_wr_addr, s_wr_data}),
    .s_req_ready(s_wr_ready),
    .m_req_valid(m_wr_valid), .m_req_ready(m_wr_ready), .m_req_pay(m_wr_pay),
    .loc_fire(wr_loc_fire), .loc_rsp(loc_wr_resp),
    .m_rsp_valid(m_wb_valid), .m_rsp_ready(m_wb_ready), .m_rsp_pay(m_wb_resp),
    .s_rsp_valid(s_wb_valid), .s_rsp_ready(s_wb_ready), .s_rsp_pay(s_wb_resp)
  );
  assign m_wr_addr = m_wr_pay[WREQ_W-1:DATA_W];
  assign m_wr_data = m_wr_pay[DATA_W-1:0];

  rs_chan #(.REQ_W(ADDR_W), .RSP_W(RRSP_W), .DEPTH(DEPTH)) u_rchan (
    .clk(clk), .rst_n(rst_n),
    .s_req_valid(s_rd_valid), .s_req_route(rd_route), .s_req_pay(s_rd_addr),
    .s_req_ready(s_rd_ready),
    .m_req_valid(m_rd_valid), .m_req_ready(m_rd_ready), .m_req_pay(m_rd_addr),
    .loc_fire(rd_loc_fire), .loc_rsp({loc_rd_data, loc_rd_resp}),
    .m_rsp_valid(m_rr_valid), .m_rsp_ready(m_rr_ready), .m_rsp_pay({m_rr_data, m_rr_resp}),
    .s_rsp_valid(s_rr_valid), .s_rsp_ready(s_rr_ready), .s_rsp_pay(s_rr_pay)
  );
  assign s_rr_data = s_rr_pay[RRSP_W-1:2];
  assign s_rr_resp = s_rr_pay[1:0];

  rs_regbank #(.DW(DATA_W), .IDX_W(IDX_W), .NREG(NREG), .SREG(SREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_loc_fire), .wr_sel(s_wr_addr[CS2_BIT]), .wr_idx(s_wr_addr[CS2_BIT-1:2]),
    .wr_data(s_wr_data), .wr_resp(loc_wr_resp),
    .rd_sel(s_rd_addr[CS2_BIT]), .rd_idx(s_rd_addr[CS2_BIT-1:2]),
    .rd_data(loc_rd_data), .rd_resp(loc_rd_resp)
  );

  // R1: a locally routed read is never presented outbound
  a_r1_rd_local_held: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd_valid && rd_route) |-> !m_rd_valid);
  // R2: a locally routed write is never presented outbound
  a_r2_wr_local_held: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr_valid && wr_route) |-> !m_wr_valid);
  // R3: outbound request carries the initiator address unchanged
  a_r3_rd_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd_valid |-> (s_rd_valid && m_rd_addr == s_rd_addr));
endmodule

// File: tb/dbi_route_switch_bench.sv
`timescale 1ns/1ps
module dbi_route_switch_bench;
  localparam logic [31:0] KEY = 32'hA5A5_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic s_wr_valid = 0, s_wr_ready, s_wb_valid, s_wb_ready = 0;
  logic [31:0] s_wr_addr = 0, s_wr_data = 0;
  logic [23:0] s_wr_misc = 0, s_rd_misc = 0;
  logic [1:0] s_wb_resp, s_rr_resp;
  logic s_rd_valid = 0, s_rd_ready, s_rr_valid, s_rr_ready = 0;
  logic [31:0] s_rd_addr = 0, s_rr_data;
  logic m_wr_valid, m_wb_valid, m_wb_ready, m_rd_valid, m_rr_valid, m_rr_ready;
  logic [31:0] m_wr_addr, m_wr_data, m_rd_addr, m_rr_data;
  logic ob_req_rdy = 1, ob_rsp_en = 1;

  // outbound target model
  logic [31:0] ob_rq [16];
  int ob_rh = 0, ob_rt = 0, ob_wcnt = 0, ob_wtotal = 0;
  logic [31:0] ob_last_waddr = 0, ob_last_wdata = 0;

  assign m_rr_valid = ob_rsp_en && (ob_rt != ob_rh);
  assign m_rr_data  = ob_rq[ob_rh[3:0]] ^ KEY;
  assign m_wb_valid = ob_rsp_en && (ob_wcnt > 0);

  always @(posedge clk) begin
    if (m_rd_valid && ob_req_rdy) begin
      ob_rq[ob_rt[3:0]] <= m_rd_addr;
      ob_rt <= ob_rt + 1;
    end
    if (m_rr_valid && m_rr_ready) ob_rh <= ob_rh + 1;
    ob_wcnt <= ob_wcnt + ((m_wr_valid && ob_req_rdy) ? 1 : 0) - ((m_wb_valid && m_wb_ready) ? 1 : 0);
    if (m_wr_valid && ob_req_rdy) begin
      ob_wtotal <= ob_wtotal + 1;
      ob_last_waddr <= m_wr_addr;
      ob_last_wdata <= m_wr_data;
    end
  end

  dbi_route_switch u_dbi_route_switch (
    .clk(clk), .rst_n(rst_n),
    .s_wr_valid(s_wr_valid), .s_wr_ready(s_wr_ready), .s_wr_addr(s_wr_addr),
    .s_wr_data(s_wr_data), .s_wr_misc(s_wr_misc),
    .s_wb_valid(s_wb_valid), .s_wb_ready(s_wb_ready), .s_wb_resp(s_wb_resp),
    .s_rd_valid(s_rd_valid), .s_rd_ready(s_rd_ready), .s_rd_addr(s_rd_addr), .s_rd_misc(s_rd_misc),
    .s_rr_valid(s_rr_valid), .s_rr_ready(s_rr_ready), .s_rr_data(s_rr_data), .s_rr_resp(s_rr_resp),
    .m_wr_valid(m_wr_valid), .m_wr_ready(ob_req_rdy), .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data),
    .m_wb_valid(m_wb_valid), .m_wb_ready(m_wb_ready), .m_wb_resp(2'b01),
    .m_rd_valid(m_rd_valid), .m_rd_ready(ob_req_rdy), .m_rd_addr(m_rd_addr),
    .m_rr_valid(m_rr_valid), .m_rr_ready(m_rr_ready), .m_rr_data(m_rr_data), .m_rr_resp(2'b01)
  );

  int checks = 0, errors = 0;
  logic [31:0] nexp [8];
  logic [31:0] sexp [4];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_misc(input logic loc);
    return (24'h5AA5C3 & ~(24'h1 << 21)) | (24'(loc) << 21);
  endfunction

  task automatic send_rd(input logic [31:0] a, input logic loc);
    @(negedge clk);
    s_rd_valid = 1; s_rd_addr = a; s_rd_misc = mk_misc(loc);
    #1;
    while (!s_rd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_rd_valid = 0;
  endtask

  task automatic send_wr(input logic [31:0] a, input logic [31:0] d, input logic loc);
    @(negedge clk);
    s_wr_valid = 1; s_wr_addr = a; s_wr_data = d; s_wr_misc = mk_misc(loc);
    #1;
    while (!s_wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_wr_valid = 0;
  endtask

  task automatic get_rr(output logic [31:0] d, output logic [1:0] r);
    @(negedge clk);
    s_rr_ready = 1;
    #1;
    while (!s_rr_valid) begin @(negedge clk); #1; end
    d = s_rr_data; r = s_rr_resp;
    @(posedge clk); #1;
    s_rr_ready = 0;
  endtask

  task automatic get_wb(output logic [1:0] r);
    @(negedge clk);
    s_wb_ready = 1;
    #1;
    while (!s_wb_valid) begin @(negedge clk); #1; end
    r = s_wb_resp;
    @(posedge clk); #1;
    s_wb_ready = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic loc, output logic [31:0] d, output logic [1:0] r);
    send_rd(a, loc);
    get_rr(d, r);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic loc, output logic [1:0] r);
    send_wr(a, d, loc);
    get_wb(r);
  endtask

  function automatic logic [31:0] na(input int i);
    return 32'(i) << 2;
  endfunction
  function automatic logic [31:0] sa(input int i);
    return (32'h1 << 12) | (32'(i) << 2);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2, a;
    logic [1:0] r, r2;
    int tw, trd;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    #1;
    chk("R10 rr_valid", s_rr_valid, 0);
    chk("R10 wb_valid", s_wb_valid, 0);
    rd(na(0), 1, d, r); chk("R10 normal reset", {d, r}, {32'h0, 2'b00});
    rd(sa(0), 1, d, r); chk("R10 shadow reset", {d, r}, {32'h0, 2'b00});

    // R2 R5 R8 sweep over normal bank and beyond
    tw = ob_wtotal;
    for (int i = 0; i < 10; i++) begin
      d = 32'h1000_0000 + 32'(i) * 32'h111;
      wr(na(i), d, 1, r);
      chk(i < 8 ? "R2 local wr resp" : "R8 unmapped wr resp", r, i < 8 ? 2'b00 : 2'b10);
      if (i < 8) nexp[i] = d;
    end
    for (int i = 0; i < 6; i++) begin
      d = 32'h5000_0000 + 32'(i);
      wr(sa(i), d, 1, r);
      chk("R5 shadow wr resp", r, i < 4 ? 2'b00 : 2'b10);
      if (i < 4) sexp[i] = d;
    end
    chk("R2 no outbound write", 32'(ob_wtotal), 32'(tw));

    // R1 R5 R8 read back
    trd = ob_rt;
    for (int i = 0; i < 10; i++) begin
      rd(na(i), 1, d, r);
      if (i < 8) chk("R1 R5 normal read", {d, r}, {nexp[i], 2'b00});
      else       chk("R8 unmapped normal read", {d, r}, {32'hFFFF_FFFF, 2'b10});
    end
    for (int i = 0; i < 6; i++) begin
      rd(sa(i), 1, d, r);
      if (i < 4) chk("R5 shadow read", {d, r}, {sexp[i], 2'b00});
      else       chk("R8 unmapped shadow read", {d, r}, {32'hFFFF_FFFF, 2'b10});
    end
    chk("R1 no outbound read", 32'(ob_rt), 32'(trd));

    // R3 outbound reads and writes
    for (int i = 0; i < 6; i++) begin
      a = 32'h4000_0000 + 32'(i) * 4 + ((i % 2 == 1) ? 32'h1000 : 32'h0);
      rd(a, 0, d, r);
      chk("R3 outbound read", {d, r}, {a ^ KEY, 2'b01});
    end
    // R6 outbound write with CS2 set never reaches shadow
    wr(sa(0), 32'hDEAD_BEEF, 0, r);
    chk("R3 R6 outbound wr resp", r, 2'b01);
    chk("R3 forwarded addr", ob_last_waddr, sa(0));
    chk("R3 forwarded data", ob_last_wdata, 32'hDEAD_BEEF);
    rd(sa(0), 1, d, r);
    chk("R6 shadow untouched", {d, r}, {sexp[0], 2'b00});

    // R4 independent channels in the same cycle
    fork
      send_wr(na(2), 32'h2222_0002, 1);
      send_rd(32'h6000_0040, 0);
    join
    fork
      get_wb(r);
      get_rr(d, r2);
    join
    nexp[2] = 32'h2222_0002;
    chk("R4 local wr resp", r, 2'b00);
    chk("R4 outbound rd", {d, r2}, {32'h6000_0040 ^ KEY, 2'b01});
    fork
      send_wr(32'h7000_0010, 32'h0BAD_F00D, 0);
      send_rd(na(2), 1);
    join
    fork
      get_wb(r);
      get_rr(d, r2);
    join
    chk("R4 outbound wr resp", r, 2'b01);
    chk("R4 local rd", {d, r2}, {nexp[2], 2'b00});

    // R11 same-cycle local read and write of one word
    fork
      send_wr(na(5), 32'h5555_AAAA, 1);
      send_rd(na(5), 1);
    join
    fork
      get_wb(r);
      get_rr(d, r2);
    join
    chk("R11 read sees old", {d, r2}, {nexp[5], 2'b00});
    nexp[5] = 32'h5555_AAAA;
    rd(na(5), 1, d, r);
    chk("R11 new value visible", {d, r}, {nexp[5], 2'b00});

    // R7 R9 ordering across paths and response hold
    ob_rsp_en = 0;
    send_rd(na(1), 1);
    send_rd(32'h4400_0008, 0);
    send_rd(na(3), 1);
    repeat (2) @(negedge clk);
    #1;
    chk("R9 held valid", s_rr_valid, 1);
    chk("R9 held data", s_rr_data, nexp[1]);
    @(negedge clk); #1;
    chk("R9 still held", {s_rr_valid, s_rr_data}, {1'b1, nexp[1]});
    get_rr(d, r); chk("R7 first", {d, r}, {nexp[1], 2'b00});
    @(negedge clk); #1;
    chk("R7 local waits behind outbound", s_rr_valid, 0);
    ob_rsp_en = 1;
    get_rr(d, r); chk("R7 second", {d, r}, {32'h4400_0008 ^ KEY, 2'b01});
    get_rr(d, r); chk("R7 third", {d, r}, {nexp[3], 2'b00});

    // R9 outbound back-pressure
    ob_req_rdy = 0;
    @(negedge clk);
    s_wr_valid = 1; s_wr_addr = 32'h7100_0000; s_wr_data = 32'h1234_5678; s_wr_misc = mk_misc(0);
    #1;
    chk("R9 ready low under back-pressure", s_wr_ready, 0);
    chk("R9 outbound valid shown", m_wr_valid, 1);
    tw = ob_wtotal;
    @(negedge clk); #1;
    chk("R9 not accepted", 32'(ob_wtotal), 32'(tw));
    ob_req_rdy = 1;
    #1;
    chk("R9 ready follows", s_wr_ready, 1);
    @(posedge clk); #1;
    s_wr_valid = 0;
    get_wb(r);
    chk("R9 completes", {ob_last_wdata, r}, {32'h1234_5678, 2'b01});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule